// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit timer channel. Software or surrounding logic writes a reload value with a one-cycle strobe and picks one of six operating modes. After that, every assertion of the count-enable tick moves the channel one step on. The channel presents the current down-count value and a single output pin. The waveform on that pin depends on the mode: a level that rises at terminal count, a retriggered one-shot, a periodic one-tick pulse, a square wave, or a one-tick strobe.

A gate input qualifies counting. In the terminal-count and software-strobe modes, the gate level pauses or enables ticks. In the one-shot, rate, square-wave and hardware-strobe modes, a rising gate edge restarts timing from the loaded value. Counting is binary only. A reload value of zero stands for a full period of 65536 ticks.

Top module: `ivt_channel`

## Requirements
- R1: After synchronous reset, `count` reads 0x0000, `out` is low, and the channel is in mode 0 with a period of 65536.
- R2: A `load_stb` pulse captures `load_val` and `mode` and restarts timing. On the next cycle `count` equals the loaded value, and a `tick` in the same cycle as the strobe is not counted.
- R3: In mode 0, `out` is low after a load and rises once the number of counted ticks reaches the period. It stays high until the next load. While `gate` is low, ticks are ignored and `count` and `out` hold.
- R4: In mode 1, `out` is low from a load or a gate trigger until the period has elapsed, then high. The gate level has no effect on counting.
- R5: In modes 2 and 6, `count` is the period minus (ticks mod period). `out` is low only during the tick interval in which a period has just completed, and never before the first completed period.
- R6: In modes 3 and 7, with p = ticks mod period, `out` is high while 2p < period, which means the first (period+1)/2 ticks of each period. `count` reads period − (2p mod period).
- R7: In modes 4 and 5, `out` is high only while the counted ticks equal the period exactly, and it does not repeat. In mode 4 the gate level pauses counting, and in mode 5 a rising gate edge restarts timing.
- R8: In modes 0, 1, 4 and 5, `count` keeps decrementing past zero and wraps to 0xFFFF.
- R9: Mode codes 6 and 7 behave exactly like codes 2 and 3.
- R10: In modes 1, 2, 3 and 5, a rising edge on `gate` restarts timing, so that `count` shows the full period on the next cycle.
- R11: A loaded value of 0 acts as a period of 65536 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count-enable, one step per cycle it is high |
| load_stb | input | 1 | Capture reload value and mode, restart timing |
| load_val | input | 16 | Reload value (0 means 65536) |
| mode | input | 3 | Operating mode code 0..7 |
| gate | input | 1 | Gate: level enable or edge trigger, by mode |
| count | output | 16 | Current visible down-count |
| out | output | 1 | Mode-dependent output waveform |

## Verification
The bench drives count expiry at exactly the period. A design that compares off by one would raise the output of mode 0 or fire the strobe one tick early or late. It also checks wrap past zero, where a saturating counter would read 0x0000 instead of 0xFFFE. The square-wave checks use an odd period, so a wrong half-period split or a single-step decrement gives the wrong count or output level. Other tests cover a zero load (a design without the 65536 rule reads a count near zero), a gate trigger in mode 1 that must pull the output low again, and a tick that coincides with a load and must be dropped.

// File: rtl/ivt_pkg.sv
// Shared types and mode helpers for the interval counter channel.
// Assumes mode codes 6 and 7 fold onto 2 and 3.
package ivt_pkg;

    typedef enum logic [2:0] {
        M_TERM    = 3'd0,
        M_ONESHOT = 3'd1,
        M_RATE    = 3'd2,
        M_SQUARE  = 3'd3,
        M_SWSTB   = 3'd4,
        M_HWSTB   = 3'd5
    } ivt_mode_e;

    // Map a raw 3-bit code to one of the six modes.
    function automatic ivt_mode_e fold_mode(input logic [2:0] code);
        case (code)
            3'd6:    return M_RATE;
            3'd7:    return M_SQUARE;
            default: return ivt_mode_e'(code);
        endcase
    endfunction

    // True when the gate level pauses counting.
    function automatic logic gate_is_level(input ivt_mode_e m);
        return (m == M_TERM) || (m == M_SWSTB);
    endfunction

    // True when the rate or square mode restarts automatically each period.
    function automatic logic is_periodic(input ivt_mode_e m);
        return (m == M_RATE) || (m == M_SQUARE);
    endfunction

endpackage

// File: rtl/ivt_gate_ctrl.sv
// Gate handling: detects a rising gate edge and turns raw ticks into count steps.
// Assumes gate is synchronous to clk. A restart is raised only in edge-triggered modes.
module ivt_gate_ctrl
    import ivt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      gate,
    input  logic      tick,
    input  ivt_mode_e mode_q,
    output logic      restart,
    output logic      step
);

    logic gate_q;

    // Remember the previous gate level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate;
    end

    // Decide restart and step from the mode class.
    always_comb begin
        restart = gate && !gate_q && !gate_is_level(mode_q);
        step    = tick && (gate_is_level(mode_q) ? gate : 1'b1);
    end

endmodule

// File: rtl/ivt_elapsed.sv
// Timing state: captured period and mode, elapsed tick count with a
// past-terminal flag, and the phase within a period for periodic modes.
// Assumes a load takes priority over a restart, and a restart over a step.
module ivt_elapsed
    import ivt_pkg::*;
#(
    parameter int CW = 16,
    localparam int PW = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_stb,
    input  logic [CW-1:0] load_val,
    input  logic [2:0]    mode_in,
    input  logic          restart,
    input  logic          step,
    output ivt_mode_e     mode_q,
    output logic [PW-1:0] per,
    output logic [PW-1:0] elapsed,
    output logic          past,
    output logic [PW-1:0] phase,
    output logic          wrapped
);

    localparam logic [PW-1:0] FULL = PW'(1) << CW;

    logic [PW-1:0] phase_nx;

    // Next phase value inside the current period.
    always_comb phase_nx = phase + 1'b1;

    // Update the timing state on load, restart or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= M_TERM;
            per     <= FULL;
            elapsed <= '0;
            past    <= 1'b0;
            phase   <= '0;
            wrapped <= 1'b0;
        end else if (load_stb) begin
            mode_q  <= fold_mode(mode_in);
            per     <= (load_val == '0) ? FULL : {1'b0, load_val};
            elapsed <= '0;
            past    <= 1'b0;
            phase   <= '0;
            wrapped <= 1'b0;
        end else if (restart) begin
            elapsed <= '0;
            past    <= 1'b0;
            phase   <= '0;
            wrapped <= 1'b0;
        end else if (step) begin
            elapsed <= elapsed + 1'b1;
            if (elapsed == per) past <= 1'b1;
            if (phase_nx == per) begin
                phase   <= '0;
                wrapped <= 1'b1;
            end else begin
                phase   <= phase_nx;
            end
        end
    end

endmodule

// File: rtl/ivt_out_decode.sv
// Turns the timing state into the visible count and the output pin level.
// Purely combinational; assumes phase < per and per in 1..2^CW.
module ivt_out_decode
    import ivt_pkg::*;
#(
    parameter int CW = 16,
    localparam int PW = CW + 1
) (
    input  ivt_mode_e     mode_q,
    input  logic [PW-1:0] per,
    input  logic [PW-1:0] elapsed,
    input  logic          past,
    input  logic [PW-1:0] phase,
    input  logic          wrapped,
    output logic [CW-1:0] count,
    output logic          out
);

    logic [PW:0] dbl;
    logic        first_half;
    logic        at_term;

    // Helper terms: doubled phase, half-period test, terminal hit.
    always_comb begin
        dbl        = {phase, 1'b0};
        first_half = dbl < {1'b0, per};
        at_term    = (elapsed == per);
    end

    // Select count and output per mode.
    always_comb begin
        count = per[CW-1:0] - elapsed[CW-1:0];
        out   = 1'b0;
        case (mode_q)
            M_TERM, M_ONESHOT: out = past || at_term;
            M_RATE: begin
                count = per[CW-1:0] - phase[CW-1:0];
                out   = !(wrapped && (phase == '0));
            end
            M_SQUARE: begin
                count = first_half ? (per[CW-1:0] - dbl[CW-1:0])
                                   : ((per[CW-1:0] << 1) - dbl[CW-1:0]);
                out   = first_half;
            end
            M_SWSTB, M_HWSTB: out = at_term && !past;
            default: out = 1'b0;
        endcase
    end

endmodule

// File: rtl/ivt_channel.sv
// Top of one programmable interval counter channel.
// Assumes tick, gate and load_stb are synchronous single-cycle-qualified inputs.
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int CW = 16,
    localparam int PW = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load_stb,
    input  logic [CW-1:0] load_val,
    input  logic [2:0]    mode,
    input  logic          gate,
    output logic [CW-1:0] count,
    output logic          out
);

    ivt_mode_e     mode_q;
    logic [PW-1:0] per;
    logic [PW-1:0] elapsed;
    logic [PW-1:0] phase;
    logic          past;
    logic          wrapped;
    logic          restart;
    logic          step;

    ivt_gate_ctrl u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate    (gate),
        .tick    (tick),
        .mode_q  (mode_q),
        .restart (restart),
        .step    (step)
    );

    ivt_elapsed #(.CW(CW)) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_stb (load_stb),
        .load_val (load_val),
        .mode_in  (mode),
        .restart  (restart),
        .step     (step),
        .mode_q   (mode_q),
        .per      (per),
        .elapsed  (elapsed),
        .past     (past),
        .phase    (phase),
        .wrapped  (wrapped)
    );

    ivt_out_decode #(.CW(CW)) u_dec (
        .mode_q  (mode_q),
        .per     (per),
        .elapsed (elapsed),
        .past    (past),
        .phase   (phase),
        .wrapped (wrapped),
        .count   (count),
        .out     (out)
    );

endmodule

// File: rtl/ivt_channel_chk.sv
// Property checker for ivt_channel, attached by bind.
module ivt_channel_chk
    import ivt_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          load_stb,
    input logic [CW-1:0] load_val,
    input logic          gate,
    input logic [CW-1:0] count,
    input logic          out,
    input ivt_mode_e     mode_q,
    input logic [CW:0]   per
);

    // R2
    load_shows_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (count == $past(load_val)));

    // R3
    term_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_TERM && out && !load_stb) |=> out);

    // R3
    term_gate_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_TERM && !gate && !load_stb) |=> ($stable(count) && $stable(out)));

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_SWSTB && out && tick && gate && !load_stb) |=> !out);

    // R5
    rate_low_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_RATE && !out) |-> (count == per[CW-1:0]));

endmodule

bind ivt_channel ivt_channel_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load_stb (load_stb),
    .load_val (load_val),
    .gate     (gate),
    .count    (count),
    .out      (out),
    .mode_q   (mode_q),
    .per      (per)
);

// File: tb/ivt_channel_tb.sv
`timescale 1ns/1ps
module ivt_channel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        load_stb = 1'b0;
    logic [15:0] load_val = '0;
    logic [2:0]  mode = '0;
    logic        gate = 1'b0;
    logic [15:0] count;
    logic        out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ivt_channel u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load_stb(load_stb),
        .load_val(load_val), .mode(mode), .gate(gate),
        .count(count), .out(out)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  md;
        logic [15:0] ld;
        logic [7:0]  nt;
        logic [15:0] ecnt;
        logic        eout;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{4'd3,  3'd0, 16'd5, 8'd4, 16'h0001, 1'b0},  // R3 before expiry
        '{4'd3,  3'd0, 16'd5, 8'd5, 16'h0000, 1'b1},  // R3 at expiry
        '{4'd8,  3'd0, 16'd5, 8'd7, 16'hFFFE, 1'b1},  // R8 wrap
        '{4'd4,  3'd1, 16'd3, 8'd2, 16'h0001, 1'b0},  // R4
        '{4'd4,  3'd1, 16'd3, 8'd3, 16'h0000, 1'b1},  // R4
        '{4'd5,  3'd2, 16'd4, 8'd0, 16'h0004, 1'b1},  // R5 no pulse at start
        '{4'd5,  3'd2, 16'd4, 8'd3, 16'h0001, 1'b1},  // R5
        '{4'd5,  3'd2, 16'd4, 8'd4, 16'h0004, 1'b0},  // R5 pulse
        '{4'd5,  3'd2, 16'd4, 8'd5, 16'h0003, 1'b1},  // R5 pulse over
        '{4'd6,  3'd3, 16'd5, 8'd2, 16'h0001, 1'b1},  // R6
        '{4'd6,  3'd3, 16'd5, 8'd3, 16'h0004, 1'b0},  // R6
        '{4'd6,  3'd3, 16'd5, 8'd4, 16'h0002, 1'b0},  // R6
        '{4'd6,  3'd3, 16'd5, 8'd5, 16'h0005, 1'b1},  // R6 new period
        '{4'd7,  3'd4, 16'd3, 8'd2, 16'h0001, 1'b0},  // R7
        '{4'd7,  3'd4, 16'd3, 8'd3, 16'h0000, 1'b1},  // R7 strobe
        '{4'd7,  3'd4, 16'd3, 8'd4, 16'hFFFF, 1'b0},  // R7 no repeat, wraps
        '{4'd7,  3'd5, 16'd2, 8'd2, 16'h0000, 1'b1},  // R7 mode 5
        '{4'd9,  3'd6, 16'd4, 8'd4, 16'h0004, 1'b0},  // R9 code 6
        '{4'd9,  3'd7, 16'd4, 8'd2, 16'h0004, 1'b0},  // R9 code 7
        '{4'd11, 3'd2, 16'd0, 8'd3, 16'hFFFD, 1'b1},  // R11 rate
        '{4'd11, 3'd0, 16'd0, 8'd1, 16'hFFFF, 1'b0}   // R11 term
    };

    task automatic chk(input string tag, input logic [15:0] ec, input logic eo);
        checks += 2;
        if (count !== ec) begin
            failures++;
            $display("FAIL %s count actual=%h expected=%h", tag, count, ec);
        end
        if (out !== eo) begin
            failures++;
            $display("FAIL %s out actual=%b expected=%b", tag, out, eo);
        end
    endtask

    task automatic do_load(input logic [2:0] m, input logic [15:0] v);
        @(negedge clk);
        mode = m; load_val = v; load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic set_gate(input logic g);
        @(negedge clk); gate = g;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset", 16'h0000, 1'b0);

        set_gate(1'b1);
        for (int k = 0; k < NV; k++) begin
            do_load(VEC[k].md, VEC[k].ld);
            do_ticks(int'(VEC[k].nt));
            chk($sformatf("R%0d vec%0d", VEC[k].req, k), VEC[k].ecnt, VEC[k].eout);
        end

        // R3: gate low pauses mode 0
        set_gate(1'b0);
        do_load(3'd0, 16'd5);
        do_ticks(3);
        chk("R3 paused", 16'd5, 1'b0);
        set_gate(1'b1);
        do_ticks(5);
        chk("R3 resumed", 16'd0, 1'b1);

        // R4 and R10: mode 1 trigger, gate level ignored
        set_gate(1'b0);
        do_load(3'd1, 16'd3);
        do_ticks(5);
        chk("R4 no trigger", 16'hFFFE, 1'b1);
        set_gate(1'b1);
        chk("R10 trigger", 16'd3, 1'b0);
        set_gate(1'b0);
        do_ticks(3);
        chk("R4 expired gate low", 16'd0, 1'b1);

        // R10: rate mode restart on rising gate
        do_load(3'd2, 16'd4);
        do_ticks(2);
        chk("R10 rate before", 16'd2, 1'b1);
        set_gate(1'b1);
        chk("R10 rate restarted", 16'd4, 1'b1);

        // R7: mode 5 retrigger repeats the strobe
        do_load(3'd5, 16'd2);
        do_ticks(3);
        chk("R7 hw strobe past", 16'hFFFF, 1'b0);
        set_gate(1'b0);
        set_gate(1'b1);
        chk("R7 hw restarted", 16'd2, 1'b0);
        do_ticks(2);
        chk("R7 hw strobe again", 16'd0, 1'b1);

        // R2: tick coincident with load is dropped
        @(negedge clk);
        mode = 3'd0; load_val = 16'd7; load_stb = 1'b1; tick = 1'b1;
        @(negedge clk);
        load_stb = 1'b0; tick = 1'b0;
        chk("R2 load wins", 16'd7, 1'b0);
        do_ticks(1);
        chk("R2 after tick", 16'd6, 1'b0);

        // R1: reset mid-run returns to idle state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 re-reset", 16'h0000, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule